// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on an SDRAM-style command bus in front of a flash array. It watches row-activate, column-write and load-command-register (LCR) commands, together with the bank, the row/column address and the 16-bit write data. It recognises the command sequences that start a flash operation. When a sequence completes, it emits a one-cycle request that carries the operation code, the target bank, row and column, and the write data. The request goes to the array controller, which is outside this block.

Two paths start an operation. On the hardware path, an LCR supplies an 8-bit opcode on the low address bits. An ACTIVE then opens the target row, and a WRITE names the target column. For opcodes that need a confirm code, the low data byte of that WRITE must equal the code. A wrong code raises a sticky error flag. On the software path, three unlock writes with fixed addresses and data arm the decoder. The next write becomes a program request. Each write takes its row from the most recent ACTIVE to the same bank.

Top module: `fcs_decoder`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it rises, `req_o` and `seq_err_o` are 0. Reset also forgets every open row.
- R2: The command encodings on `cmd_i` are 0 = NOP, 1 = ACTIVE, 2 = WRITE and 3 = LCR. An LCR latches `addr_i[7:0]` as the opcode. An ACTIVE to bank B then opens row `addr_i[11:0]`. A WRITE to bank B then completes the sequence, and the request carries that opcode, bank B, the open row, column `addr_i[7:0]` and `data_i`.
- R3: The opcodes 20h, 60h and 30h need the confirm codes D0h, 01h and D0h, compared against `data_i[7:0]` of the completing WRITE. A matching code gives the request. Any other opcode needs no code.
- R4: A wrong confirm code issues no request and sets `seq_err_o`. The flag stays set until `clr_err_i` is high at a clock edge with no new error. If a new error and `clr_err_i` come in the same cycle, the flag stays set.
- R5: The three unlock writes, in order, are: bank 0, row 000h, column 55h, data byte 00h; then bank 0, row 055h, column 2Ah, data byte 55h; then bank 0, row 080h, column 40h, data byte A0h. Only `data_i[7:0]` is compared. The next write to any bank with an open row gives a request with opcode 40h, that write's bank, row and column, and the full `data_i`.
- R6: During an unlock or hardware sequence, any WRITE that is not the expected step aborts the sequence with no request. This covers a wrong unlock step, a WRITE before the ACTIVE, and a WRITE to a bank other than the last activated one.
- R7: An LCR at any point, including partway through an unlock, abandons the current sequence and starts a hardware sequence with the new opcode.
- R8: A WRITE to a bank that has had no ACTIVE since reset never matches an unlock step and never completes a request.
- R9: `req_o` is high for exactly one cycle, in the cycle after the completing WRITE is sampled.
- R10: When idle, NOPs, ACTIVEs and WRITEs that do not match the first unlock step produce no request and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Bus command: 0 NOP, 1 ACTIVE, 2 WRITE, 3 LCR |
| bank_i | input | 2 | Bank select |
| addr_i | input | 12 | Row on ACTIVE, column/opcode on WRITE/LCR |
| data_i | input | 16 | Write data |
| clr_err_i | input | 1 | Clears the sequence error flag |
| req_o | output | 1 | One-cycle operation request |
| req_op_o | output | 8 | Request opcode |
| req_bank_o | output | 2 | Request bank |
| req_row_o | output | 12 | Request row |
| req_col_o | output | 8 | Request column |
| req_data_o | output | 16 | Request data |
| seq_err_o | output | 1 | Sticky confirm-mismatch flag |

## Verification
On every cycle, the assertions check the following. A request is a single-cycle pulse that always follows a WRITE. An ACTIVE or an LCR is never followed by a request. The error flag rises only after a WRITE and never together with a request, and it holds or clears as `clr_err_i` dictates. Only the bench's scenarios, compared against its behavioural model, can show the rest. This covers whether the right sequence fires, the captured opcode, row, column and data, aborts on wrong steps, LCR pre-emption of an unlock, and writes to banks never opened.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_WR  = 2'd2,
    CMD_LCR = 2'd3
  } fcs_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_ARMED,
    ST_HW_ACT,
    ST_HW_WR
  } fcs_state_e;
endpackage

// File: rtl/fcs_row_track.sv
module fcs_row_track #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [ROW_W-1:0]  act_row_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [ROW_W-1:0]  rd_row_o,
  output logic              rd_open_o
);
  logic [ROW_W-1:0] row_q  [NBANK];
  logic             open_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q[b]  <= '0;
        open_q[b] <= 1'b0;
      end else if (act_i && act_bank_i == BANK_W'(b)) begin
        row_q[b]  <= act_row_i;
        open_q[b] <= 1'b1;
      end
    end
  end

  assign rd_row_o  = row_q[rd_bank_i];
  assign rd_open_o = open_q[rd_bank_i];
endmodule

// File: rtl/fcs_unlock_match.sv
module fcs_unlock_match #(
  parameter int N_STEP = 3,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int KEY_W  = 8,
  parameter logic [N_STEP*BANK_W-1:0] STEP_BANKS = '0,
  parameter logic [N_STEP*ROW_W-1:0]  STEP_ROWS  = '0,
  parameter logic [N_STEP*COL_W-1:0]  STEP_COLS  = '0,
  parameter logic [N_STEP*KEY_W-1:0]  STEP_KEYS  = '0
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [N_STEP-1:0] hit_o
);
  for (genvar s = 0; s < N_STEP; s++) begin : g_step
    assign hit_o[s] = (bank_i == STEP_BANKS[s*BANK_W +: BANK_W])
                   && (row_i  == STEP_ROWS[s*ROW_W +: ROW_W])
                   && (col_i  == STEP_COLS[s*COL_W +: COL_W])
                   && (key_i  == STEP_KEYS[s*KEY_W +: KEY_W]);
  end
endmodule

// File: rtl/fcs_confirm_lut.sv
module fcs_confirm_lut #(
  parameter int N_CONF = 3,
  parameter int OP_W   = 8,
  parameter logic [N_CONF*OP_W-1:0] CONF_OPS   = '0,
  parameter logic [N_CONF*OP_W-1:0] CONF_CODES = '0
) (
  input  logic [OP_W-1:0] op_i,
  output logic            need_o,
  output logic [OP_W-1:0] code_o
);
  logic [N_CONF-1:0] hit;
  logic [OP_W-1:0]   code_m [N_CONF];

  for (genvar c = 0; c < N_CONF; c++) begin : g_ent
    assign hit[c]    = (op_i == CONF_OPS[c*OP_W +: OP_W]);
    assign code_m[c] = hit[c] ? CONF_CODES[c*OP_W +: OP_W] : '0;
  end

  always_comb begin
    code_o = '0;
    for (int c = 0; c < N_CONF; c++) code_o = code_o | code_m[c];
  end

  assign need_o = |hit;
endmodule

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import fcs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int OP_W   = 8,
  parameter int N_CONF = 3,
  parameter logic [N_CONF*OP_W-1:0] CONF_OPS   = 24'h30_60_20,
  parameter logic [N_CONF*OP_W-1:0] CONF_CODES = 24'hD0_01_D0,
  parameter logic [OP_W-1:0]        SW_OP      = 8'h40,
  parameter logic [3*BANK_W-1:0]    UNL_BANKS  = '0,
  parameter logic [3*ROW_W-1:0]     UNL_ROWS   = 36'h080_055_000,
  parameter logic [3*COL_W-1:0]     UNL_COLS   = 24'h40_2A_55,
  parameter logic [3*OP_W-1:0]      UNL_KEYS   = 24'hA0_55_00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_err_i,
  output logic              req_o,
  output logic [OP_W-1:0]   req_op_o,
  output logic [BANK_W-1:0] req_bank_o,
  output logic [ROW_W-1:0]  req_row_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              seq_err_o
);
  localparam int N_STEP = 3;

  fcs_cmd_e   cmd;
  fcs_state_e state_q, state_d;
  logic [OP_W-1:0]   op_q, op_d, fire_op, conf_code;
  logic [BANK_W-1:0] hbank_q, hbank_d;
  logic [ROW_W-1:0]  wr_row;
  logic [N_STEP-1:0] step_hit;
  logic wr_open, need_conf, fire, err_set;
  logic req_q, err_q;
  logic [OP_W-1:0]   rq_op_q;
  logic [BANK_W-1:0] rq_bank_q;
  logic [ROW_W-1:0]  rq_row_q;
  logic [COL_W-1:0]  rq_col_q;
  logic [DATA_W-1:0] rq_data_q;

  assign cmd = fcs_cmd_e'(cmd_i);

  fcs_row_track #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (cmd == CMD_ACT),
    .act_bank_i (bank_i),
    .act_row_i  (addr_i),
    .rd_bank_i  (bank_i),
    .rd_row_o   (wr_row),
    .rd_open_o  (wr_open)
  );

  fcs_unlock_match #(
    .N_STEP(N_STEP), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .KEY_W(OP_W),
    .STEP_BANKS(UNL_BANKS), .STEP_ROWS(UNL_ROWS), .STEP_COLS(UNL_COLS), .STEP_KEYS(UNL_KEYS)
  ) u_unlock (
    .bank_i (bank_i),
    .row_i  (wr_row),
    .col_i  (addr_i[COL_W-1:0]),
    .key_i  (data_i[OP_W-1:0]),
    .hit_o  (step_hit)
  );

  fcs_confirm_lut #(
    .N_CONF(N_CONF), .OP_W(OP_W), .CONF_OPS(CONF_OPS), .CONF_CODES(CONF_CODES)
  ) u_conf (
    .op_i   (op_q),
    .need_o (need_conf),
    .code_o (conf_code)
  );

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    hbank_d = hbank_q;
    fire    = 1'b0;
    fire_op = op_q;
    err_set = 1'b0;
    case (cmd)
      CMD_LCR: begin
        op_d    = addr_i[OP_W-1:0];
        state_d = ST_HW_ACT;
      end
      CMD_ACT: begin
        // only the hardware path cares which bank was opened last
        if (state_q == ST_HW_ACT || state_q == ST_HW_WR) begin
          hbank_d = bank_i;
          state_d = ST_HW_WR;
        end
      end
      CMD_WR: begin
        state_d = ST_IDLE;
        case (state_q)
          ST_IDLE:  if (wr_open && step_hit[0]) state_d = ST_UNL1;
          ST_UNL1:  if (wr_open && step_hit[1]) state_d = ST_UNL2;
          ST_UNL2:  if (wr_open && step_hit[2]) state_d = ST_ARMED;
          ST_ARMED: begin
            if (wr_open) begin
              fire    = 1'b1;
              fire_op = SW_OP;
            end
          end
          ST_HW_WR: begin
            if (wr_open && bank_i == hbank_q) begin
              if (!need_conf || data_i[OP_W-1:0] == conf_code) fire = 1'b1;
              else                                            err_set = 1'b1;
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      hbank_q   <= '0;
      req_q     <= 1'b0;
      err_q     <= 1'b0;
      rq_op_q   <= '0;
      rq_bank_q <= '0;
      rq_row_q  <= '0;
      rq_col_q  <= '0;
      rq_data_q <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      hbank_q <= hbank_d;
      req_q   <= fire;
      err_q   <= err_set | (err_q & ~clr_err_i);
      if (fire) begin
        rq_op_q   <= fire_op;
        rq_bank_q <= bank_i;
        rq_row_q  <= wr_row;
        rq_col_q  <= addr_i[COL_W-1:0];
        rq_data_q <= data_i;
      end
    end
  end

  assign req_o      = req_q;
  assign req_op_o   = rq_op_q;
  assign req_bank_o = rq_bank_q;
  assign req_row_o  = rq_row_q;
  assign req_col_o  = rq_col_q;
  assign req_data_o = rq_data_q;
  assign seq_err_o  = err_q;
endmodule

// File: rtl/fcs_decoder_chk.sv
module fcs_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cmd_i,
  input logic       clr_err_i,
  input logic       req_o,
  input logic       seq_err_o
);
  p_req_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  p_req_after_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(cmd_i) == 2'd2);

  p_lcr_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 2'd3 |=> !req_o);

  p_act_no_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 2'd1 |=> !req_o);

  p_err_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o && !clr_err_i |=> seq_err_o);

  p_err_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_i && cmd_i != 2'd2 |=> !seq_err_o);

  p_err_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_err_o) |-> !req_o && $past(cmd_i) == 2'd2);
endmodule

bind fcs_decoder fcs_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     (cmd_i),
  .clr_err_i (clr_err_i),
  .req_o     (req_o),
  .seq_err_o (seq_err_o)
);

// File: tb/fcs_decoder_bench.sv
`timescale 1ns/1ps
module fcs_decoder_bench;
  localparam logic [1:0] C_NOP = 2'd0, C_ACT = 2'd1, C_WR = 2'd2, C_LCR = 2'd3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cmd_i = C_NOP;
  logic [1:0]  bank_i = '0;
  logic [11:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic        clr_err_i = 1'b0;
  logic        req_o, seq_err_o;
  logic [7:0]  req_op_o, req_col_o;
  logic [1:0]  req_bank_o;
  logic [11:0] req_row_o;
  logic [15:0] req_data_o;

  fcs_decoder u_fcs_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i), .addr_i(addr_i),
    .data_i(data_i), .clr_err_i(clr_err_i), .req_o(req_o), .req_op_o(req_op_o),
    .req_bank_o(req_bank_o), .req_row_o(req_row_o), .req_col_o(req_col_o),
    .req_data_o(req_data_o), .seq_err_o(seq_err_o)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0, fails = 0, nreq = 0;
  bit done = 0;
  string tag = "R1";
  logic [7:0]  last_op;
  logic [1:0]  last_bank;
  logic [11:0] last_row;
  logic [7:0]  last_col;
  logic [15:0] last_data;

  // behavioural reference
  int          mst;            // 0 idle,1..2 unlock progress,3 armed,4 want ACTIVE,5 want WRITE
  logic [11:0] orow [4];
  bit          oval [4];
  logic [7:0]  mop;
  logic [1:0]  mhb;
  bit          e_req, e_err;
  logic [7:0]  e_op, e_col;
  logic [1:0]  e_bank;
  logic [11:0] e_row;
  logic [15:0] e_data;
  int urow [3] = '{12'h000, 12'h055, 12'h080};
  int ucol [3] = '{8'h55, 8'h2A, 8'h40};
  int ukey [3] = '{8'h00, 8'h55, 8'hA0};

  function automatic int conf_of(logic [7:0] op);
    case (op)
      8'h20: return 8'hD0;
      8'h60: return 8'h01;
      8'h30: return 8'hD0;
      default: return -1;
    endcase
  endfunction

  function automatic bit step_ok(int s, logic [1:0] b, logic [11:0] r, logic [7:0] c, logic [7:0] k);
    return b == 2'd0 && r == 12'(urow[s]) && c == 8'(ucol[s]) && k == 8'(ukey[s]);
  endfunction

  task automatic issue(logic [7:0] op, logic [11:0] r);
    e_req = 1; e_op = op; e_bank = bank_i; e_row = r; e_col = addr_i[7:0]; e_data = data_i;
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mst = 0; mop = 0; mhb = 0; e_req = 0; e_err = 0;
      for (int b = 0; b < 4; b++) begin orow[b] = 0; oval[b] = 0; end
    end else begin
      bit ok; logic [11:0] r;
      e_req = 0;
      if (clr_err_i) e_err = 0;
      case (cmd_i)
        C_LCR: begin mop = addr_i[7:0]; mst = 4; end
        C_ACT: begin
          orow[bank_i] = addr_i; oval[bank_i] = 1;
          if (mst == 4 || mst == 5) begin mhb = bank_i; mst = 5; end
        end
        C_WR: begin
          ok = oval[bank_i]; r = orow[bank_i];
          if (mst <= 2) begin
            if (ok && step_ok(mst, bank_i, r, addr_i[7:0], data_i[7:0])) mst = mst + 1;
            else mst = 0;
          end else if (mst == 3) begin
            if (ok) issue(8'h40, r);
            mst = 0;
          end else if (mst == 5) begin
            if (ok && bank_i == mhb) begin
              if (conf_of(mop) < 0 || int'(data_i[7:0]) == conf_of(mop)) issue(mop, r);
              else e_err = 1;
            end
            mst = 0;
          end else mst = 0;
        end
        default: ;
      endcase
    end
  end

  task automatic fail_line(string t, string what, logic [31:0] act, logic [31:0] exp);
    fails++;
    $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (req_o !== e_req) fail_line(tag, "req_o", 32'(req_o), 32'(e_req));
      else if (e_req && {req_op_o, req_bank_o, req_row_o, req_col_o, req_data_o} !==
                        {e_op, e_bank, e_row, e_col, e_data})
        fail_line(tag, "request fields",
                  {req_op_o, req_bank_o, req_row_o[9:0], req_col_o[3:0]},
                  {e_op, e_bank, e_row[9:0], e_col[3:0]});
      checks++;
      if (seq_err_o !== e_err) fail_line(tag, "seq_err_o", 32'(seq_err_o), 32'(e_err));
      if (req_o === 1'b1) begin
        nreq++;
        last_op = req_op_o; last_bank = req_bank_o; last_row = req_row_o;
        last_col = req_col_o; last_data = req_data_o;
      end
    end
  end

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) fail_line(t, what, act, exp);
  endtask

  task automatic drive(logic [1:0] c, logic [1:0] b, logic [11:0] a, logic [15:0] d, bit clr);
    @(negedge clk_i);
    cmd_i = c; bank_i = b; addr_i = a; data_i = d; clr_err_i = clr;
  endtask
  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive(C_NOP, 0, 0, 0, 0);
  endtask
  task automatic act(logic [1:0] b, logic [11:0] r); drive(C_ACT, b, r, 0, 0); endtask
  task automatic wr(logic [1:0] b, logic [11:0] c, logic [15:0] d); drive(C_WR, b, c, d, 0); endtask
  task automatic lcr(logic [7:0] op); drive(C_LCR, 0, {4'h0, op}, 0, 0); endtask
  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0; cmd_i = C_NOP; clr_err_i = 0;
    nop(2);
    @(negedge clk_i); rst_ni = 1;
  endtask
  task automatic unlock3();
    act(0, 12'h000); wr(0, 12'h055, 16'h0000);
    act(0, 12'h055); wr(0, 12'h02A, 16'h0055);
    act(0, 12'h080); wr(0, 12'h040, 16'h00A0);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n0;
    do_reset();
    tag = "R1";
    #1;
    chk("R1", "req_o after reset", 32'(req_o), 0);
    chk("R1", "seq_err_o after reset", 32'(seq_err_o), 0);

    tag = "R2"; n0 = nreq;
    lcr(8'h40); act(1, 12'h123); wr(1, 12'h045, 16'hBEEF); nop(2);
    chk("R2", "request count", nreq - n0, 1);
    chk("R2", "op/bank/row", {last_op, last_bank, last_row}, {8'h40, 2'd1, 12'h123});
    chk("R2", "col/data", {last_col, last_data}, {8'h45, 16'hBEEF});

    tag = "R3"; n0 = nreq;
    lcr(8'h20); act(2, 12'h0F0); wr(2, 12'h011, 16'h77D0); nop(2);
    lcr(8'h60); act(3, 12'h001); wr(3, 12'h022, 16'h0001); nop(2);
    chk("R3", "confirmed requests", nreq - n0, 2);
    chk("R3", "last op", last_op, 8'h60);

    tag = "R4"; n0 = nreq;
    lcr(8'h30); act(0, 12'h010); wr(0, 12'h000, 16'h00D1); nop(3);
    chk("R4", "no request on bad code", nreq - n0, 0);
    chk("R4", "error set", 32'(seq_err_o), 1);
    drive(C_NOP, 0, 0, 0, 1); nop(1);
    chk("R4", "error cleared", 32'(seq_err_o), 0);
    lcr(8'h20); act(0, 12'h010); drive(C_WR, 0, 12'h000, 16'h0000, 1); nop(1);
    chk("R4", "set wins over clear", 32'(seq_err_o), 1);
    drive(C_NOP, 0, 0, 0, 1); nop(1);

    tag = "R5"; n0 = nreq;
    unlock3(); act(2, 12'h321); wr(2, 12'h010, 16'h1234); nop(2);
    chk("R5", "program request count", nreq - n0, 1);
    chk("R5", "op/bank/row", {last_op, last_bank, last_row}, {8'h40, 2'd2, 12'h321});
    chk("R5", "data", last_data, 16'h1234);
    n0 = nreq;
    unlock3(); wr(0, 12'h000, 16'hFF00); nop(2);
    chk("R5", "data high byte free in target", last_data, 16'hFF00);

    tag = "R6"; n0 = nreq;
    act(0, 12'h000); wr(0, 12'h055, 16'h0000);
    act(0, 12'h055); wr(0, 12'h02A, 16'h0056);
    act(0, 12'h080); wr(0, 12'h040, 16'h00A0);
    act(1, 12'h002); wr(1, 12'h003, 16'h4444); nop(2);
    lcr(8'h40); wr(0, 12'h001, 16'h1111); act(0, 12'h003); nop(2);
    lcr(8'h40); act(1, 12'h005); wr(2, 12'h001, 16'h2222); nop(2);
    chk("R6", "aborted sequences give no request", nreq - n0, 0);
    chk("R6", "no error from aborts", 32'(seq_err_o), 0);

    tag = "R7"; n0 = nreq;
    act(0, 12'h000); wr(0, 12'h055, 16'h0000);
    act(0, 12'h055); wr(0, 12'h02A, 16'h0055);
    lcr(8'h10); act(1, 12'h0AA); wr(1, 12'h0BB, 16'h5A5A); nop(2);
    chk("R7", "LCR pre-empts unlock", nreq - n0, 1);
    chk("R7", "opcode from LCR", last_op, 8'h10);

    tag = "R8"; do_reset(); n0 = nreq;
    wr(0, 12'h055, 16'h0000);
    act(0, 12'h055); wr(0, 12'h02A, 16'h0055);
    act(0, 12'h080); wr(0, 12'h040, 16'h00A0);
    act(1, 12'h005); wr(1, 12'h001, 16'h1234); nop(2);
    unlock3(); wr(3, 12'h001, 16'h9999); nop(2);
    chk("R8", "unopened bank never fires", nreq - n0, 0);

    tag = "R10"; n0 = nreq;
    act(2, 12'h055); wr(2, 12'h055, 16'h0000); wr(0, 12'h054, 16'h0000);
    drive(C_NOP, 3, 12'hFFF, 16'hFFFF, 0); act(0, 12'h000); nop(2);
    chk("R10", "idle noise", nreq - n0, 0);
    chk("R10", "no error from noise", 32'(seq_err_o), 0);

    tag = "R9"; n0 = nreq;
    unlock3(); act(1, 12'h00C); wr(1, 12'h0C0, 16'hC0DE); wr(1, 12'h0C1, 16'hC0DF); nop(3);
    chk("R9", "single pulse per sequence", nreq - n0, 1);

    tag = "R2,R5 random";
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 11);
      logic [1:0] b = (k % 3 == 0) ? 2'd0 : 2'($urandom_range(0, 3));
      if (k == 11) begin unlock3(); continue; end
      case (k)
        0, 1: drive(C_NOP, b, 12'($urandom), 16'($urandom), 0);
        2, 3: begin
          int rs = $urandom_range(0, 3);
          act(b, rs < 3 ? 12'(urow[rs]) : 12'($urandom));
        end
        4, 5, 6, 7: begin
          int cs = $urandom_range(0, 3);
          int ds = $urandom_range(0, 5);
          logic [15:0] dv;
          case (ds)
            0: dv = 16'h0000; 1: dv = 16'h0055; 2: dv = 16'h00A0;
            3: dv = 16'h00D0; 4: dv = 16'h0001; default: dv = 16'($urandom);
          endcase
          wr(b, cs < 3 ? 12'(ucol[cs]) : 12'($urandom_range(0, 255)), dv);
        end
        8, 9: begin
          int os = $urandom_range(0, 4);
          logic [7:0] ov;
          case (os) 0: ov = 8'h20; 1: ov = 8'h30; 2: ov = 8'h60; 3: ov = 8'h40; default: ov = 8'h10; endcase
          lcr(ov);
        end
        default: drive(C_NOP, 0, 0, 0, 1);
      endcase
    end
    nop(3);
    summary();
  end
endmodule